// File: doc/BRIEF.md
# Oscillator Band Selection Sequencer

This block times and steers the automatic band choice of a multi-band oscillator that covers eight overlapping frequency bands. A selection run starts on its own when reset is released. It starts again whenever the feedback-counter latch is written, which the surrounding logic signals with a one-cycle strobe. While a run is active, the block drives an override output. That output detaches the oscillator's tuning input from the loop filter and ties it to a fixed internal reference. At the end of the run the override is released and normal loop action resumes.

The run is timed by a band-select clock. This clock is made from the reference-divider output pulse, which is divided again by 1, 2, 4 or 8. A run lasts exactly five of these divided ticks. During the first three ticks a successive-approximation search settles the 3-bit band index, one bit per tick, from a comparator input. The analog comparison itself is outside this block. The band index then holds until the next run starts.

All logic runs on one system clock. The reference-divider pulse and the trigger strobe are both one-clock pulses that are synchronous to that clock.

Top module: `vco_band_seq`

## Requirements
- R1: While reset is low and after it is released, `busy` and `tune_override` are 1, `done` is 0 and `band` is 3'b100. A selection run therefore starts at power-up with no trigger.
- R2: A `trig` pulse sampled at a clock edge sets `busy` to 1 and `band` to 3'b100 from that edge on. It also restarts the pre-divider phase, so the next divided tick needs a full group of reference pulses.
- R3: `busy` stays 1 for exactly five divided ticks. It goes to 0 at the edge that samples the fifth tick, and not at any earlier tick.
- R4: `div_sel` sets how many `ref_tick` pulses make one divided tick: 2'b00 gives 1, 2'b01 gives 2, 2'b10 gives 4 and 2'b11 gives 8.
- R5: The band index is found by binary search. At divided ticks 1, 2 and 3, `cmp_hi` is sampled into `band[2]`, `band[1]` and `band[0]` in that order, where 1 keeps the trial bit and 0 clears it. The final `band` is therefore {cmp at tick 1, cmp at tick 2, cmp at tick 3}. `cmp_hi` at ticks 4 and 5 has no effect.
- R6: A `trig` pulse during a run restarts the five-tick count and the search. When `trig` and a divided tick arrive on the same edge, the trigger wins: that tick is neither counted nor allowed to end the run.
- R7: Once a run has ended, `band` holds its value and `busy` stays 0, whatever `ref_tick` and `cmp_hi` do, until the next `trig`.
- R8: `tune_override` is 1 exactly while `busy` is 1.
- R9: `done` is a single-cycle pulse. It is 1 in the first cycle after the edge at which `busy` falls, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low; starts a power-up run |
| ref_tick | input | 1 | One-cycle pulse from the reference divider |
| div_sel | input | 2 | Pre-divider select: 00 /1, 01 /2, 10 /4, 11 /8 |
| trig | input | 1 | One-cycle strobe on a feedback-counter latch write |
| cmp_hi | input | 1 | Band comparator result; 1 keeps the trial bit |
| tune_override | output | 1 | Ties the tuning input to the internal reference while high |
| busy | output | 1 | High during a selection run |
| done | output | 1 | One-cycle pulse when a run finishes |
| band | output | 3 | Chosen band index; holds after the run |

## Verification
The bound checker watches four things on every cycle:
- that each run ends only after five divided ticks have been counted since its start;
- that `done` is a lone pulse that coincides with the fall of `busy`;
- that a trigger always leads to a fresh run with the seed band;
- that `band` never moves while the block is idle.

Other properties can only be shown by the bench's scenarios, because they depend on the stimulus:
- the reference-pulse counts for each divider setting;
- the mapping from comparator answers to the final band;
- how a retrigger mid-run and a trigger coinciding with a tick are resolved;
- the state after power-up.

// File: rtl/vbs_pkg.sv
// Package: shared constants and types for the band selection sequencer.
// Assumes a single synchronous clock domain for every user.
package vbs_pkg;
    // Pre-divider settings, encoded as the log2 of the divide ratio
    typedef enum logic [1:0] {
        DIV_BY1 = 2'b00,
        DIV_BY2 = 2'b01,
        DIV_BY4 = 2'b10,
        DIV_BY8 = 2'b11
    } div_sel_e;

    // Default band count is eight, so the index is three bits wide
    localparam int unsigned BAND_W_DEF = 3;
    // Default run length in divided ticks
    localparam int unsigned STEPS_DEF  = 5;
endpackage

// File: rtl/vbs_prediv.sv
// Module: pre-divider that turns reference-divider pulses into band-select ticks.
// It counts ref_tick pulses and emits bs_tick on the last pulse of each group
// of 2**div_sel pulses. restart zeroes the phase.
// Assumes ref_tick is a one-cycle pulse.
module vbs_prediv #(
    parameter int unsigned DSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              ref_tick,
    input  logic [DSEL_W-1:0] div_sel,
    output logic              bs_tick
);
    localparam int unsigned MAXDIV = 1 << ((1 << DSEL_W) - 1);
    localparam int unsigned CNT_W  = (MAXDIV > 1) ? $clog2(MAXDIV) : 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   ratio;
    logic [CNT_W:0]   cnt_next;
    logic             last;

    // Divide ratio and the test for the last pulse of a group
    always_comb begin
        ratio    = (CNT_W+1)'(1) << div_sel;
        cnt_next = {1'b0, cnt} + (CNT_W+1)'(1);
        last     = (cnt_next >= ratio);
    end

    // Phase counter over reference pulses
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
        end else if (ref_tick) begin
            if (last) cnt <= '0;
            else      cnt <= cnt_next[CNT_W-1:0];
        end
    end

    assign bs_tick = ref_tick & last;
endmodule

// File: rtl/vbs_cycle_ctr.sv
// Module: run timer that counts STEPS band-select ticks.
// busy rises on reset or start and falls on the final tick, when done
// pulses for one cycle. start has priority over a coincident tick.
module vbs_cycle_ctr #(
    parameter int unsigned STEPS = 5,
    localparam int unsigned CW   = $clog2(STEPS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          tick,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] step
);
    localparam logic [CW-1:0] LAST_STEP = CW'(STEPS - 1);

    // Run state: reset behaves like a power-up start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b1;
            done <= 1'b0;
            step <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy <= 1'b1;
                step <= '0;
            end else if (busy && tick) begin
                if (step == LAST_STEP) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    step <= '0;
                end else begin
                    step <= step + CW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/vbs_search.sv
// Module: successive-approximation register for the band index.
// It starts at the mid code. At step k (k < BAND_W) it writes the comparator
// into bit BAND_W-1-k and sets the next lower bit as the new trial.
// It holds its value outside those steps. Assumes step counts ticks of the run.
module vbs_search #(
    parameter int unsigned BAND_W = 3,
    parameter int unsigned CW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tick,
    input  logic              busy,
    input  logic [CW-1:0]     step,
    input  logic              cmp,
    output logic [BAND_W-1:0] band
);
    localparam logic [BAND_W-1:0] SEED = BAND_W'(1) << (BAND_W - 1);

    logic [BAND_W-1:0] trial;
    logic              active;

    // Next trial code: resolve the current bit and probe the one below it
    always_comb begin
        trial  = band;
        active = busy && tick && (int'(step) < int'(BAND_W));
        for (int i = 0; i < int'(BAND_W); i++) begin
            if (i == int'(BAND_W) - 1 - int'(step))      trial[i] = cmp;
            else if (i == int'(BAND_W) - 2 - int'(step)) trial[i] = 1'b1;
        end
    end

    // Band register: seeded at each run start, updated on search steps
    always_ff @(posedge clk) begin
        if (!rst_n || start) band <= SEED;
        else if (active)     band <= trial;
    end
endmodule

// File: rtl/vco_band_seq.sv
// Module: top of the oscillator band selection sequencer.
// It joins the pre-divider, the run timer and the search register. The
// tuning override follows the run state.
// Assumes ref_tick and trig are one-cycle pulses synchronous to clk.
module vco_band_seq #(
    parameter int unsigned BAND_W = vbs_pkg::BAND_W_DEF,
    parameter int unsigned STEPS  = vbs_pkg::STEPS_DEF,
    parameter int unsigned DSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic [DSEL_W-1:0] div_sel,
    input  logic              trig,
    input  logic              cmp_hi,
    output logic              tune_override,
    output logic              busy,
    output logic              done,
    output logic [BAND_W-1:0] band
);
    localparam int unsigned CW = $clog2(STEPS + 1);

    logic          bs_tick;
    logic [CW-1:0] step;

    vbs_prediv #(.DSEL_W(DSEL_W)) u_prediv (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (trig),
        .ref_tick (ref_tick),
        .div_sel  (div_sel),
        .bs_tick  (bs_tick)
    );

    vbs_cycle_ctr #(.STEPS(STEPS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (trig),
        .tick  (bs_tick),
        .busy  (busy),
        .done  (done),
        .step  (step)
    );

    vbs_search #(.BAND_W(BAND_W), .CW(CW)) u_sar (
        .clk   (clk),
        .rst_n (rst_n),
        .start (trig),
        .tick  (bs_tick),
        .busy  (busy),
        .step  (step),
        .cmp   (cmp_hi),
        .band  (band)
    );

    // Tuning path override is held for the whole run
    assign tune_override = busy;
endmodule

// File: rtl/vbs_band_seq_chk.sv
// Module: property checker for vco_band_seq, attached by bind.
// It keeps its own count of divided ticks since each run start.
module vbs_band_seq_chk #(
    parameter int unsigned BAND_W = 3,
    parameter int unsigned STEPS  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig,
    input logic              bs_tick,
    input logic              busy,
    input logic              done,
    input logic [BAND_W-1:0] band
);
    localparam int unsigned TW = $clog2(STEPS + 1) + 1;
    localparam logic [BAND_W-1:0] SEED = BAND_W'(1) << (BAND_W - 1);

    logic [TW-1:0] tk;

    // Independent tick tally for the current run
    always_ff @(posedge clk) begin
        if (!rst_n || trig)      tk <= '0;
        else if (busy && bs_tick) tk <= tk + TW'(1);
    end

    // R2
    trig_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (busy && band == SEED));

    // R3
    run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (tk == TW'(STEPS)));

    // R3
    no_early_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (tk == TW'(STEPS)));

    // R9
    done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !trig) |=> ($stable(band) && !busy));
endmodule

bind vco_band_seq vbs_band_seq_chk #(.BAND_W(BAND_W), .STEPS(STEPS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig    (trig),
    .bs_tick (bs_tick),
    .busy    (busy),
    .done    (done),
    .band    (band)
);

// File: tb/vco_band_seq_test.sv
`timescale 1ns/1ps
// Bench: directed scenarios for vco_band_seq, one task per scenario.
module vco_band_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic [1:0] div_sel = 2'b00;
    logic       trig = 1'b0;
    logic       cmp_hi = 1'b0;
    logic       tune_override, busy, done;
    logic [2:0] band;

    int n_chk = 0;
    int n_bad = 0;
    logic saw_done;

    vco_band_seq uut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .div_sel(div_sel),
        .trig(trig), .cmp_hi(cmp_hi), .tune_override(tune_override),
        .busy(busy), .done(done), .band(band)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // One reference pulse with a comparator value; records done after the edge
    task automatic ref_pulse(input logic c);
        @(negedge clk); ref_tick = 1'b1; cmp_hi = c;
        @(posedge clk); #1 saw_done = done;
        @(negedge clk); ref_tick = 1'b0;
    endtask

    task automatic pulse_trig();
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
    endtask

    // Feed five divided ticks with comparator answers c2,c1,c0 and check the run
    task automatic feed_run(input int ratio, input logic c2, input logic c1, input logic c0,
                            input string tag);
        logic [2:0] exp_band = {c2, c1, c0};
        for (int t = 0; t < 5; t++) begin
            for (int k = 0; k < ratio; k++) begin
                logic c = (t == 0) ? c2 : (t == 1) ? c1 : (t == 2) ? c0 : ~c0;
                ref_pulse(c);
                if (!(t == 4 && k == ratio - 1))
                    check(busy && tune_override && !saw_done,
                          {tag, " R3 R4 busy held before fifth tick"}, busy, 1);
            end
        end
        check(saw_done == 1'b1, {tag, " R9 done on fifth tick"}, saw_done, 1);
        check(busy == 1'b0, {tag, " R3 busy falls on fifth tick"}, busy, 0);
        check(tune_override == 1'b0, {tag, " R8 override released"}, tune_override, 0);
        check(band == exp_band, {tag, " R5 band result"}, band, exp_band);
        @(posedge clk); #1;
        check(done == 1'b0, {tag, " R9 done single cycle"}, done, 0);
    endtask

    task automatic t_powerup();
        rst_n = 1'b0; div_sel = 2'b00;
        repeat (3) @(negedge clk);
        check(busy && tune_override && !done && band == 3'b100,
              "R1 state in reset", {busy, tune_override, done, band}, 6'b110100);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(busy && band == 3'b100, "R1 run starts after reset", band, 3'b100);
        feed_run(1, 1'b1, 1'b0, 1'b1, "powerup");
    endtask

    task automatic t_divider(input logic [1:0] sel, input logic c2, input logic c1,
                             input logic c0, input string tag);
        div_sel = sel;
        pulse_trig();
        check(busy && tune_override && band == 3'b100, {tag, " R2 trigger starts run"}, band, 3'b100);
        feed_run(1 << sel, c2, c1, c0, tag);
    endtask

    task automatic t_retrigger();
        div_sel = 2'b00;
        pulse_trig();
        ref_pulse(1'b0); ref_pulse(1'b0);
        pulse_trig();
        check(busy && band == 3'b100, "R6 retrigger reseeds band", band, 3'b100);
        feed_run(1, 1'b1, 1'b1, 1'b0, "retrig");
    endtask

    task automatic t_coincide();
        div_sel = 2'b00;
        pulse_trig();
        for (int i = 0; i < 4; i++) ref_pulse(1'b0);
        @(negedge clk); trig = 1'b1; ref_tick = 1'b1;
        @(posedge clk); #1;
        check(busy && !done, "R6 trigger beats coincident tick", done, 0);
        check(band == 3'b100, "R6 band reseeded on coincidence", band, 3'b100);
        @(negedge clk); trig = 1'b0; ref_tick = 1'b0;
        feed_run(1, 1'b0, 1'b0, 1'b1, "coincide");
    endtask

    task automatic t_hold();
        logic [2:0] kept = band;
        logic any_done = 1'b0;
        div_sel = 2'b00;
        for (int i = 0; i < 12; i++) begin
            ref_pulse(i[0]);
            any_done |= saw_done;
        end
        check(band == kept, "R7 band held when idle", band, kept);
        check(!busy && !tune_override && !any_done, "R7 R8 stays idle", busy, 0);
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_powerup();
        t_hold();
        t_divider(2'b01, 1'b0, 1'b1, 1'b1, "div2");
        t_divider(2'b10, 1'b1, 1'b0, 1'b0, "div4");
        t_divider(2'b11, 1'b1, 1'b1, 1'b1, "div8");
        t_divider(2'b00, 1'b0, 1'b0, 1'b0, "div1");
        t_hold();
        t_retrigger();
        t_coincide();
        t_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule